// File: doc/BRIEF.md
# Input Sample-Rate Measurement Unit

This block estimates the sampling frequency of a received serial audio stream. It runs from a fixed reference clock, nominally 24.576 MHz, and never from any clock recovered from the stream. A prescaler divides that clock by four. A window counter then counts the prescaled ticks between two consecutive frame strobes. At each strobe the count is captured and the counter restarts. The captured count is also turned into a 4-bit rate code by comparing it against tolerance windows (±3 %) placed around the nominal counts of the common audio rates.

Two measurement modes are selectable. In hold mode, results are taken only while the receiver reports an error or unlock. Once the receiver locks, the last result is frozen. A new transition into unlock clears the valid flag and starts a fresh measurement. In continuous mode, every complete frame updates the result whatever the receiver state, so the reported value follows slow drift of the input rate. The count, the code and the valid flag are available as direct outputs. Count and code can also be read through a small synchronous register port.

Top module: `fs_rate_meter`

## Requirements
- R1: The captured count equals floor(P/4), where P is the number of `clk` cycles between two consecutive `frm_stb` pulses. `rate_count` and `rate_code` change on the clock edge that samples the closing strobe.
- R2: The rate code is assigned from the count as follows: 187..197 gives 0 (32 kHz), 136..143 gives 1 (44.1 kHz), 125..131 gives 2 (48 kHz), 68..71 gives 3 (88.2 kHz), 63..65 gives 4 (96 kHz), 34..35 gives 5 (176.4 kHz), and exactly 32 gives 6 (192 kHz).
- R3: When the window reaches 255 ticks or more, the count saturates at 8'hFF and the code is 4'hF (out of range).
- R4: A count below 255 that lies in none of the R2 windows gives code 4'hE.
- R5: When `hold_mode` is 1 and `rx_err` is 0, strobes leave `rate_count`, `rate_code` and `rate_valid` unchanged.
- R6: When `hold_mode` is 1, a 0-to-1 change of `rx_err` clears `rate_valid` on the next edge. The first strobe after that only opens a window, and the second strobe delivers the new result.
- R7: When `hold_mode` is 0, every complete window updates the result whatever the level of `rx_err`, and a rise of `rx_err` does not clear `rate_valid`.
- R8: After reset, the first strobe only opens a window and `rate_valid` stays 0. `rate_valid` becomes 1 with the first captured result.
- R9: Register reads are synchronous. With `rd_en` high, address 0 returns {4'b0, code} and address 1 returns the count on the following edge. With `rd_en` low, `rd_data` keeps its value.
- R10: Synchronous active-high reset sets the count, code, valid flag and `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed reference clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_stb | input | 1 | One-cycle pulse at each received frame boundary |
| rx_err | input | 1 | Receiver error/unlock flag, 1 = unlocked |
| hold_mode | input | 1 | 1 = hold measurement, 0 = continuous |
| rd_en | input | 1 | Register read enable |
| rd_addr | input | 1 | Register address: 0 = code, 1 = count |
| rd_data | output | 8 | Registered read data |
| rate_count | output | 8 | Last captured tick count |
| rate_code | output | 4 | Last rate code |
| rate_valid | output | 1 | A complete measurement is held |

## Verification
The hardest case to reach is the re-arm path of hold mode. This needs a result taken while unlocked, then a locked stretch in which the input rate changes but the output must not, then a fresh unlock. After the unlock, the first strobe must be discarded and only the second may load the new rate. The stimulus walks through exactly that order, using two clearly different frame periods so that a stale value or a half-window capture shows up as a wrong count. The code windows are probed at their edges (136, 143 and 144 ticks) and at saturation, by picking strobe spacings in `clk` cycles that are four times the wanted count.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int CODE_W      = 4;
  localparam int NUM_RATES   = 7;
  localparam logic [CODE_W-1:0] CODE_NOMATCH = 4'hE;
  localparam logic [CODE_W-1:0] CODE_OOR     = 4'hF;

  // Nominal sampling rates in Hz, indexed by rate code
  function automatic longint rate_hz(input int idx);
    case (idx)
      0:       return 64'd32000;
      1:       return 64'd44100;
      2:       return 64'd48000;
      3:       return 64'd88200;
      4:       return 64'd96000;
      5:       return 64'd176400;
      default: return 64'd192000;
    endcase
  endfunction

  // Lowest tick count accepted for a rate (rounded up)
  function automatic int win_lo(input int idx, input longint ref_hz,
                                input int prescale, input int tol_pct);
    longint num, den;
    num = ref_hz * longint'(100 - tol_pct);
    den = longint'(prescale) * rate_hz(idx) * 64'd100;
    return int'((num + den - 64'd1) / den);
  endfunction

  // Highest tick count accepted for a rate (rounded down)
  function automatic int win_hi(input int idx, input longint ref_hz,
                                input int prescale, input int tol_pct);
    longint num, den;
    num = ref_hz * longint'(100 + tol_pct);
    den = longint'(prescale) * rate_hz(idx) * 64'd100;
    return int'(num / den);
  endfunction
endpackage

// File: rtl/srm_tick_counter.sv
module srm_tick_counter #(
  parameter int PRESCALE = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] win_cnt
);
  localparam int DIV_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);
  // the restart cycle itself is the first reference cycle of the new window
  localparam logic [DIV_W-1:0] DIV_SEED = DIV_W'(1 % PRESCALE);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [DIV_W-1:0] div_q;
  logic             tick;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      win_cnt <= '0;
    end else if (restart) begin
      div_q   <= DIV_SEED;
      win_cnt <= '0;
    end else if (tick) begin
      div_q <= '0;
      if (win_cnt != CNT_MAX) win_cnt <= win_cnt + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R3: a full window stays pinned at the top value
  a_r3_saturate: assert property (@(posedge clk) disable iff (rst)
    (win_cnt == CNT_MAX && !restart) |=> (win_cnt == CNT_MAX));

  // R1: between restarts the window only ever advances by one tick
  a_r1_single_step: assert property (@(posedge clk) disable iff (rst)
    !restart |=> (win_cnt == $past(win_cnt) || win_cnt == $past(win_cnt) + 1'b1));
endmodule

// File: rtl/srm_rate_classify.sv
module srm_rate_classify #(
  parameter longint REF_HZ   = 64'd24576000,
  parameter int     PRESCALE = 4,
  parameter int     TOL_PCT  = 3,
  parameter int     CNT_W    = 8
) (
  input  logic [CNT_W-1:0]           count,
  output logic [srm_pkg::CODE_W-1:0] code
);
  import srm_pkg::*;

  logic [NUM_RATES-1:0] hit;

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_win
    localparam int LO = win_lo(i, REF_HZ, PRESCALE, TOL_PCT);
    localparam int HI = win_hi(i, REF_HZ, PRESCALE, TOL_PCT);
    assign hit[i] = (int'(count) >= LO) && (int'(count) <= HI);
  end

  always_comb begin
    code = CODE_NOMATCH;
    if (count == '1) begin
      code = CODE_OOR;
    end else begin
      for (int i = NUM_RATES - 1; i >= 0; i--) begin
        if (hit[i]) code = CODE_W'(i);
      end
    end
  end

  // R2: the tolerance windows must never overlap
  always_comb begin
    a_r2_disjoint: assert ($onehot0(hit));
  end
endmodule

// File: rtl/srm_capture.sv
module srm_capture #(
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frm_stb,
  input  logic                       rx_err,
  input  logic                       hold_mode,
  input  logic [CNT_W-1:0]           win_cnt,
  input  logic [srm_pkg::CODE_W-1:0] win_code,
  output logic [CNT_W-1:0]           cnt_q,
  output logic [srm_pkg::CODE_W-1:0] code_q,
  output logic                       valid_q
);
  logic err_q;
  logic armed;
  logic unlock_evt;
  logic take_ok;
  logic capture;

  assign unlock_evt = hold_mode & rx_err & ~err_q;
  assign take_ok    = hold_mode ? rx_err : 1'b1;
  assign capture    = frm_stb & armed & take_ok & ~unlock_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= 1'b0;
      armed   <= 1'b0;
      cnt_q   <= '0;
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      err_q <= rx_err;
      if (unlock_evt)   armed <= 1'b0;
      else if (frm_stb) armed <= 1'b1;
      if (capture) begin
        cnt_q  <= win_cnt;
        code_q <= win_code;
      end
      if (unlock_evt)   valid_q <= 1'b0;
      else if (capture) valid_q <= 1'b1;
    end
  end

  // R5: a locked receiver in hold mode freezes the result
  a_r5_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (hold_mode && !rx_err) |=> ($stable(cnt_q) && $stable(code_q) && $stable(valid_q)));

  // R6: entering unlock in hold mode drops the valid flag
  a_r6_unlock_clears: assert property (@(posedge clk) disable iff (rst)
    (hold_mode && $rose(rx_err)) |=> !valid_q);

  // R8: the valid flag can only rise at a frame strobe
  a_r8_valid_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(frm_stb));
endmodule

// File: rtl/srm_regread.sv
module srm_regread #(
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic                       rd_addr,
  input  logic [CNT_W-1:0]           cnt_q,
  input  logic [srm_pkg::CODE_W-1:0] code_q,
  output logic [CNT_W-1:0]           rd_data
);
  localparam int PAD_W = CNT_W - srm_pkg::CODE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_addr ? cnt_q : {{PAD_W{1'b0}}, code_q};
    end
  end

  // R9: a count read returns the count present at the request edge
  a_r9_count_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr) |=> (rd_data == $past(cnt_q)));
endmodule

// File: rtl/fs_rate_meter.sv
module fs_rate_meter #(
  parameter longint REF_HZ   = 64'd24576000,
  parameter int     PRESCALE = 4,
  parameter int     TOL_PCT  = 3,
  parameter int     CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_stb,
  input  logic             rx_err,
  input  logic             hold_mode,
  input  logic             rd_en,
  input  logic             rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] rate_count,
  output logic [3:0]       rate_code,
  output logic             rate_valid
);
  logic [CNT_W-1:0] win_cnt;
  logic [3:0]       win_code;

  srm_tick_counter #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (frm_stb),
    .win_cnt (win_cnt)
  );

  srm_rate_classify #(.REF_HZ(REF_HZ), .PRESCALE(PRESCALE), .TOL_PCT(TOL_PCT),
                      .CNT_W(CNT_W)) u_cls (
    .count (win_cnt),
    .code  (win_code)
  );

  srm_capture #(.CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .frm_stb   (frm_stb),
    .rx_err    (rx_err),
    .hold_mode (hold_mode),
    .win_cnt   (win_cnt),
    .win_code  (win_code),
    .cnt_q     (rate_count),
    .code_q    (rate_code),
    .valid_q   (rate_valid)
  );

  srm_regread #(.CNT_W(CNT_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .cnt_q   (rate_count),
    .code_q  (rate_code),
    .rd_data (rd_data)
  );
endmodule

// File: tb/fs_rate_meter_test.sv
`timescale 1ns/1ps
module fs_rate_meter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm_stb = 1'b0;
  logic       rx_err = 1'b1;
  logic       hold_mode = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data, rate_count;
  logic [3:0] rate_code;
  logic       rate_valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fs_rate_meter uut (
    .clk(clk), .rst(rst), .frm_stb(frm_stb), .rx_err(rx_err),
    .hold_mode(hold_mode), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rate_count(rate_count), .rate_code(rate_code),
    .rate_valid(rate_valid)
  );

  // {strobe spacing in clk cycles, expected count, expected code}
  localparam int NVEC = 13;
  localparam int VEC [0:NVEC-1][0:2] = '{
    '{768, 192, 0}, '{556, 139, 1}, '{512, 128, 2}, '{279, 69, 3},
    '{256, 64, 4},  '{140, 35, 5},  '{128, 32, 6},  '{544, 136, 1},
    '{572, 143, 1}, '{576, 144, 14}, '{800, 200, 14}, '{1020, 255, 15},
    '{1200, 255, 15}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one-cycle strobe; returns at the negedge after the capturing edge
  task automatic pulse();
    @(negedge clk) frm_stb = 1'b1;
    @(negedge clk) frm_stb = 1'b0;
  endtask

  // two strobes spaced p cycles apart
  task automatic frame(input int p);
    pulse();
    repeat (p - 2) @(negedge clk);
    pulse();
  endtask

  task automatic do_read(input logic a);
    @(negedge clk) begin rd_en = 1'b1; rd_addr = a; end
    @(negedge clk) rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 count", rate_count, 0);
    chk("R10 code", rate_code, 0);
    chk("R10 valid", rate_valid, 0);
    chk("R10 rd_data", rd_data, 0);
    @(negedge clk) rst = 1'b0;

    // R8: first strobe only opens the window
    pulse();
    chk("R8 valid after first strobe", rate_valid, 0);
    repeat (512 - 2) @(negedge clk);
    pulse();
    chk("R8 valid after first window", rate_valid, 1);
    chk("R8 R1 first count", rate_count, 128);

    // R1 R2 R3 R4: table walk in continuous mode
    for (int i = 0; i < NVEC; i++) begin
      frame(VEC[i][0]);
      chk("R1 count", rate_count, VEC[i][1]);
      chk("R2/R3/R4 code", rate_code, VEC[i][2]);
    end

    // R7: continuous mode measures while locked
    @(negedge clk) rx_err = 1'b0;
    frame(512);
    chk("R7 locked count", rate_count, 128);
    @(negedge clk) rx_err = 1'b1;
    @(negedge clk);
    chk("R7 valid kept on unlock", rate_valid, 1);

    // R5: hold mode freezes after lock
    @(negedge clk) hold_mode = 1'b1;
    frame(768);
    chk("R5 unlocked count", rate_count, 192);
    @(negedge clk) rx_err = 1'b0;
    frame(256);
    pulse();
    chk("R5 held count", rate_count, 192);
    chk("R5 held code", rate_code, 0);
    chk("R5 held valid", rate_valid, 1);

    // R6: re-arm on unlock
    @(negedge clk) rx_err = 1'b1;
    @(negedge clk);
    chk("R6 valid cleared", rate_valid, 0);
    pulse();
    chk("R6 first strobe no capture", rate_count, 192);
    chk("R6 valid still low", rate_valid, 0);
    repeat (256 - 2) @(negedge clk);
    pulse();
    chk("R6 new count", rate_count, 64);
    chk("R6 new code", rate_code, 4);
    chk("R6 valid back", rate_valid, 1);

    // R9: register reads
    do_read(1'b0);
    chk("R9 addr0", rd_data, 4);
    do_read(1'b1);
    chk("R9 addr1", rd_data, 64);
    @(negedge clk) rd_addr = 1'b0;
    @(negedge clk);
    chk("R9 hold without rd_en", rd_data, 64);

    // R10: reset in mid run
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk("R10 count after reset", rate_count, 0);
    chk("R10 valid after reset", rate_valid, 0);
    chk("R10 rd_data after reset", rd_data, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule